// File: doc/BRIEF.md
# Moving-Inversions March Self-Test Engine

A built-in self-test controller for a single-port synchronous SRAM. A pulse on `start` launches one march pass over the whole address range. The pass has three phases. The fill phase stores the pass pattern at every address. The rising sweep reads each address, checks it against the pattern and then overwrites it with the complement. The falling sweep walks back from the top address, checks for the complement and restores the pattern. When a pass ends, `done` rises and the pass counter steps.

The pattern for each pass comes from one of four sources, chosen by `mode`. Each miscompare leaves the engine as one record on a valid/ready stream. A record carries the failing address, the expected word, the word read and the bit-wise difference. Back-pressure works like this: a record stays on the port until the consumer takes it. While a record is waiting, the engine issues no further reads, so no miscompare is ever dropped.

The memory must return read data on the clock edge after the address is presented. The engine compares that data in the cycle after the read, and it writes the same address in the cycle after the compare.

Top module: `mi_bist`

## Requirements
- R1: After reset, `busy`, `done`, `err_valid` and `mem_we` are 0 and `pass_count` is 0.
- R2: A start pulse is accepted only while idle, and `mode` is sampled at that moment. The fill phase then writes P(a) to every address, with one write per cycle, at addresses 0, 1, … DEPTH-1 in that order.
- R3: In the rising sweep each address a, from 0 up to DEPTH-1, is handled in three cycles: a read, then a compare against P(a), then a write of ~P(a).
- R4: The falling sweep runs from DEPTH-1 down to 0 with the same three-cycle rhythm. It compares against ~P(a) and writes P(a) back, so a fault-free memory ends the pass holding P(a). Without stalls a pass lasts exactly 7·DEPTH cycles.
- R5: A record is raised only on a miscompare. It gives the address, the expected word, the actual word, and `err_xor` = expected XOR actual.
- R6: Once `err_valid` is high, the record stays fixed until a cycle with `err_ready` high. While a record is waiting, no new read is started.
- R7: At the end of a pass `done` goes to 1, `busy` goes to 0 and `pass_count` increases by one. A start pulse during a pass has no effect.
- R8: Mode 0 (solid) uses P = all zeros when `pass_count` is even at start, and all ones when it is odd.
- R9: Mode 1 (walking byte) uses a step s that cycles 0..19. The byte is 1<<(s mod 8), inverted when bit 3 of s is set, and it is repeated in every byte lane.
- R10: Mode 2 (rotating bit) sets a single 1 at bit position (k + a) mod DW. Here k counts completed passes modulo DW, and a is the address.
- R11: Mode 3 (random) sets every bit i of P to bit (i mod 32) of a 32-bit Galois LFSR, the same for all addresses. The LFSR shifts right and XORs in 0x80200003 when the bit shifted out is 1. It resets to `LFSR_INIT`, is loaded from `seed` when a start is accepted with `reseed` high, and steps once at the end of every pass.
- R12: The step s, the rotation k and the LFSR all advance at the end of every completed pass, whatever mode that pass used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start one march pass (taken only when idle) |
| mode | input | 2 | Pattern source: 0 solid, 1 walking byte, 2 rotating bit, 3 random |
| reseed | input | 1 | Load `seed` into the LFSR together with an accepted start |
| seed | input | 32 | LFSR load value |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass complete; cleared by the next accepted start |
| pass_count | output | PCW | Completed passes since reset |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data, valid one cycle after the address |
| err_valid | output | 1 | Miscompare record available |
| err_ready | input | 1 | Consumer accepts the record |
| err_addr | output | AW | Failing address |
| err_exp | output | DW | Expected word |
| err_act | output | DW | Word read |
| err_xor | output | DW | Failing bit positions |

## Verification
The first fill write is on the bus in the cycle after the edge that samples `start`. Without back-pressure, `done` is first seen after the 7·DEPTH-th following edge, so the bench counts edges from that sampling edge and checks the count exactly. An error record appears one edge after the compare cycle, and the bench takes it on the edge where `err_ready` is high. Every snooped write, the final memory image and every record is compared against patterns the bench computes itself. All sampling happens on the falling edge.

// File: rtl/mi_bist_pkg.sv
package mi_bist_pkg;

  typedef enum logic [1:0] {
    PAT_SOLID = 2'd0,
    PAT_WALK8 = 2'd1,
    PAT_SHIFT = 2'd2,
    PAT_RAND  = 2'd3
  } pat_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_UP_RD,
    ST_UP_CMP,
    ST_UP_WR,
    ST_DN_RD,
    ST_DN_CMP,
    ST_DN_WR
  } march_st_e;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [31:0] lfsr_step(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? LFSR_TAPS : 32'h0);
  endfunction

endpackage

// File: rtl/mi_pat_gen.sv
module mi_pat_gen
  import mi_bist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [31:0] LFSR_INIT = 32'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pat_mode_e     mode,
  input  logic          pass_lsb,
  input  logic          pass_end,
  input  logic          reseed_ld,
  input  logic [31:0]   seed,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] pat
);
  localparam int SW    = $clog2(DW);
  localparam int LANES = DW / 8;
  localparam logic [4:0] STEP_LAST = 5'd19;

  logic [4:0]    step_q;
  logic [SW-1:0] rot_q;
  logic [31:0]   lfsr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      rot_q  <= '0;
      lfsr_q <= LFSR_INIT;
    end else if (reseed_ld) begin
      lfsr_q <= seed;
    end else if (pass_end) begin
      step_q <= (step_q == STEP_LAST) ? 5'd0 : step_q + 5'd1;
      rot_q  <= rot_q + 1'b1;
      lfsr_q <= lfsr_step(lfsr_q);
    end
  end

  logic [7:0]    walk_byte;
  logic [DW-1:0] p_walk, p_rot, p_rand;
  logic [SW-1:0] rot_idx;

  always_comb begin
    walk_byte = 8'h01 << step_q[2:0];
    if (step_q[3]) walk_byte = ~walk_byte;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign p_walk[g*8 +: 8] = walk_byte;
  end

  for (genvar b = 0; b < DW; b++) begin : g_rbit
    assign p_rand[b] = lfsr_q[b % 32];
  end

  assign rot_idx = rot_q + SW'(addr);
  assign p_rot   = {{(DW-1){1'b0}}, 1'b1} << rot_idx;

  always_comb begin
    unique case (mode)
      PAT_SOLID: pat = pass_lsb ? '1 : '0;
      PAT_WALK8: pat = p_walk;
      PAT_SHIFT: pat = p_rot;
      default:   pat = p_rand;
    endcase
  end

endmodule

// File: rtl/mi_march_seq.sv
module mi_march_seq
  import mi_bist_pkg::*;
#(
  parameter int AW  = 4,
  parameter int PCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode_in,
  input  logic           stall,
  output march_st_e      state,
  output logic [AW-1:0]  addr,
  output pat_mode_e      mode_q,
  output logic           busy,
  output logic           done,
  output logic           start_acc,
  output logic           pass_end,
  output logic [PCW-1:0] pass_count
);
  localparam logic [AW-1:0] ADDR_TOP = '1;

  assign busy      = (state != ST_IDLE);
  assign start_acc = (state == ST_IDLE) && start;
  assign pass_end  = (state == ST_DN_WR) && (addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr       <= '0;
      mode_q     <= PAT_SOLID;
      done       <= 1'b0;
      pass_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_FILL;
          addr   <= '0;
          mode_q <= pat_mode_e'(mode_in);
          done   <= 1'b0;
        end
        ST_FILL: begin
          if (addr == ADDR_TOP) begin
            state <= ST_UP_RD;
            addr  <= '0;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        ST_UP_RD:  if (!stall) state <= ST_UP_CMP;
        ST_UP_CMP: state <= ST_UP_WR;
        ST_UP_WR: begin
          if (addr == ADDR_TOP) begin
            state <= ST_DN_RD;
          end else begin
            addr  <= addr + 1'b1;
            state <= ST_UP_RD;
          end
        end
        ST_DN_RD:  if (!stall) state <= ST_DN_CMP;
        ST_DN_CMP: state <= ST_DN_WR;
        ST_DN_WR: begin
          if (addr == '0) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            pass_count <= pass_count + 1'b1;
          end else begin
            addr  <= addr - 1'b1;
            state <= ST_DN_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mi_err_port.sv
module mi_err_port #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_en,
  input  logic [AW-1:0] cmp_addr,
  input  logic [DW-1:0] cmp_exp,
  input  logic [DW-1:0] cmp_act,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_exp,
  output logic [DW-1:0] out_act,
  output logic [DW-1:0] out_xor
);
  logic miss;
  assign miss = cmp_en && (cmp_exp != cmp_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_exp   <= '0;
      out_act   <= '0;
      out_xor   <= '0;
    end else if (miss) begin
      out_valid <= 1'b1;
      out_addr  <= cmp_addr;
      out_exp   <= cmp_exp;
      out_act   <= cmp_act;
      out_xor   <= cmp_exp ^ cmp_act;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mi_bist.sv
module mi_bist
  import mi_bist_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int PCW = 16,
  parameter logic [31:0] LFSR_INIT = 32'h1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     mode,
  input  logic           reseed,
  input  logic [31:0]    seed,
  output logic           busy,
  output logic           done,
  output logic [PCW-1:0] pass_count,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           mem_we,
  input  logic [DW-1:0]  mem_rdata,
  output logic           err_valid,
  input  logic           err_ready,
  output logic [AW-1:0]  err_addr,
  output logic [DW-1:0]  err_exp,
  output logic [DW-1:0]  err_act,
  output logic [DW-1:0]  err_xor
);
  march_st_e     state;
  pat_mode_e     mode_q;
  logic [AW-1:0] addr;
  logic [DW-1:0] pat, exp_word;
  logic          start_acc, pass_end, stall, cmp_en;

  assign stall = err_valid && !err_ready;

  mi_march_seq #(.AW(AW), .PCW(PCW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode_in    (mode),
    .stall      (stall),
    .state      (state),
    .addr       (addr),
    .mode_q     (mode_q),
    .busy       (busy),
    .done       (done),
    .start_acc  (start_acc),
    .pass_end   (pass_end),
    .pass_count (pass_count)
  );

  mi_pat_gen #(.AW(AW), .DW(DW), .LFSR_INIT(LFSR_INIT)) u_pat (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .pass_lsb  (pass_count[0]),
    .pass_end  (pass_end),
    .reseed_ld (start_acc && reseed),
    .seed      (seed),
    .addr      (addr),
    .pat       (pat)
  );

  assign cmp_en   = (state == ST_UP_CMP) || (state == ST_DN_CMP);
  assign exp_word = (state == ST_UP_CMP) ? pat : ~pat;

  mi_err_port #(.AW(AW), .DW(DW)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_en    (cmp_en),
    .cmp_addr  (addr),
    .cmp_exp   (exp_word),
    .cmp_act   (mem_rdata),
    .out_ready (err_ready),
    .out_valid (err_valid),
    .out_addr  (err_addr),
    .out_exp   (err_exp),
    .out_act   (err_act),
    .out_xor   (err_xor)
  );

  assign mem_addr  = addr;
  assign mem_we    = (state == ST_FILL) || (state == ST_UP_WR) || (state == ST_DN_WR);
  assign mem_wdata = (state == ST_UP_WR) ? ~pat : pat;

endmodule

// File: rtl/mi_bist_chk.sv
module mi_bist_chk #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int PCW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic [PCW-1:0] pass_count,
  input logic           mem_we,
  input logic           err_valid,
  input logic           err_ready,
  input logic [AW-1:0]  err_addr,
  input logic [DW-1:0]  err_exp,
  input logic [DW-1:0]  err_act,
  input logic [DW-1:0]  err_xor
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  p_rec_is_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_xor != '0) && (err_exp != err_act));

  p_rec_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !err_ready |=> err_valid && $stable(err_addr) &&
      $stable(err_exp) && $stable(err_act) && $stable(err_xor));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> pass_count == PCW'($past(pass_count) + 1'b1));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind mi_bist mi_bist_chk #(.AW(AW), .DW(DW), .PCW(PCW)) u_mi_bist_chk (.*);

// File: tb/test_mi_bist.sv
module test_mi_bist;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int PCW = 16;
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0, reseed = 0, err_ready = 1;
  logic [1:0] mode = 0;
  logic [31:0] seed = 0;
  logic busy, done, mem_we, err_valid;
  logic [PCW-1:0] pass_count;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, err_exp, err_act, err_xor;

  always #2 clk = ~clk;

  mi_bist #(.AW(AW), .DW(DW), .PCW(PCW)) i_mi_bist (.*);

  logic [DW-1:0] mem [N];
  logic [DW-1:0] sa1 [N];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata | sa1[mem_addr];
    mem_rdata <= mem[mem_addr];
  end

  int wn = 0;
  logic [AW-1:0] wl_a [3*N];
  logic [DW-1:0] wl_d [3*N];
  always @(posedge clk) if (rst_n && mem_we && wn < 3*N) begin
    wl_a[wn] = mem_addr; wl_d[wn] = mem_wdata; wn++;
  end

  int en = 0;
  logic [AW-1:0] el_a [8];
  logic [DW-1:0] el_e [8], el_x [8], el_c [8];
  always @(posedge clk) if (rst_n && err_valid && err_ready && en < 8) begin
    el_a[en] = err_addr; el_e[en] = err_exp; el_c[en] = err_act; el_x[en] = err_xor; en++;
  end

  int checks = 0, fails = 0, wd = 0;
  int m_n = 0;
  logic [31:0] m_lfsr = 32'h1;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      fails++;
      $display("FAIL R7 watchdog expired: act=%0d exp<=%0d", wd, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_step(input logic [31:0] v);
    return v[0] ? ((v >> 1) ^ 32'h8020_0003) : (v >> 1);
  endfunction

  function automatic logic [DW-1:0] m_pat(input int m, input int n, input logic [31:0] l, input int a);
    logic [DW-1:0] p; logic [7:0] b; int s;
    p = '0;
    case (m)
      0: p = (n % 2 == 1) ? '1 : '0;
      1: begin
        s = n % 20; b = 8'(1 << (s % 8));
        if ((s / 8) % 2 == 1) b = ~b;
        for (int i = 0; i < DW/8; i++) p[i*8 +: 8] = b;
      end
      2: p[(n + a) % DW] = 1'b1;
      default: for (int i = 0; i < DW; i++) p[i] = l[i % 32];
    endcase
    return p;
  endfunction

  task automatic launch(input int m, input bit rs, input logic [31:0] sd);
    wn = 0; en = 0;
    @(negedge clk);
    mode = 2'(m); reseed = rs; seed = sd; start = 1;
    if (rs) m_lfsr = sd;
    @(negedge clk);
    start = 0; reseed = 0;
  endtask

  task automatic wait_done(output int cyc, input int mid_start);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (cyc == mid_start) start = 1; else start = 0;
    end
  endtask

  task automatic check_pass(input int m, input string req, input int cyc, input int exp_cyc);
    int bad_w = 0, bad_m = 0;
    logic [DW-1:0] p;
    check(cyc == exp_cyc, "R4", {req, " pass length"}, cyc, exp_cyc);
    check(wn == 3*N, "R2", {req, " write count"}, wn, 3*N);
    for (int i = 0; i < 3*N; i++) begin
      int a;
      logic [DW-1:0] d;
      a = (i < 2*N) ? i % N : (3*N - 1 - i);
      p = m_pat(m, m_n, m_lfsr, a);
      d = (i >= N && i < 2*N) ? ~p : p;
      if (wl_a[i] !== AW'(a) || wl_d[i] !== d) bad_w++;
    end
    check(bad_w == 0, "R3", {req, " write order/data mismatches"}, bad_w, 0);
    for (int a = 0; a < N; a++)
      if (mem[a] !== (m_pat(m, m_n, m_lfsr, a) | sa1[a])) bad_m++;
    check(bad_m == 0, "R4", {req, " final image mismatches"}, bad_m, 0);
    check(pass_count == PCW'(m_n + 1), "R7", {req, " pass_count"}, pass_count, m_n + 1);
    check(!busy && done, "R7", {req, " done/busy"}, {busy, done}, 2'b01);
    m_n++;
    m_lfsr = m_step(m_lfsr);
  endtask

  task automatic t_reset;
    check(!busy && !done && !err_valid && !mem_we, "R1", "idle flags", {busy, done, err_valid, mem_we}, 0);
    check(pass_count == 0, "R1", "pass_count", pass_count, 0);
  endtask

  task automatic t_plain(input int m, input string req, input bit rs, input logic [31:0] sd);
    int cyc;
    launch(m, rs, sd);
    wait_done(cyc, 0);
    check(en == 0 && !err_valid, req, "no records on clean pass", en, 0);
    check_pass(m, req, cyc, 7*N);
  endtask

  task automatic t_fault;
    int cyc; logic [DW-1:0] p, e;
    sa1[5] = 32'h8;
    p = m_pat(0, m_n, m_lfsr, 5);
    e = p[3] ? ~p : p;
    launch(0, 0, 0);
    wait_done(cyc, 0);
    check(en == 1, "R5", "record count", en, 1);
    check(el_a[0] == 5, "R5", "record addr", el_a[0], 5);
    check(el_e[0] == e, "R5", "record expected", el_e[0], e);
    check(el_c[0] == (e | 32'h8), "R5", "record actual", el_c[0], e | 32'h8);
    check(el_x[0] == 32'h8, "R5", "record xor", el_x[0], 32'h8);
    check_pass(0, "R5", cyc, 7*N);
    sa1[5] = '0;
  endtask

  task automatic t_backpressure;
    int cyc; logic [DW-1:0] p; int first, second;
    sa1[2] = 32'h1; sa1[9] = 32'h1;
    p = m_pat(0, m_n, m_lfsr, 2);
    first = p[0] ? 9 : 2; second = p[0] ? 2 : 9;
    err_ready = 0;
    launch(0, 0, 0);
    repeat (7*N + 40) @(negedge clk);
    check(busy && !done, "R6", "engine stalled", {busy, done}, 2'b10);
    check(err_valid && err_addr == AW'(first), "R6", "held record addr", err_addr, first);
    check(en == 0, "R6", "nothing taken while not ready", en, 0);
    err_ready = 1;
    wait_done(cyc, 0);
    check(en == 2, "R6", "records after release", en, 2);
    check(el_a[0] == AW'(first) && el_a[1] == AW'(second), "R6", "record order",
          {el_a[0], el_a[1]}, {AW'(first), AW'(second)});
    check_pass(0, "R6", cyc + 7*N + 40, cyc + 7*N + 40);
    sa1[2] = '0; sa1[9] = '0;
  endtask

  task automatic t_start_ignored;
    int cyc;
    launch(2, 0, 0);
    wait_done(cyc, 30);
    check_pass(2, "R7", cyc, 7*N);
    repeat (3) @(negedge clk);
    check(!busy && pass_count == PCW'(m_n), "R7", "mid-pass start ignored", pass_count, m_n);
  endtask

  initial begin
    for (int a = 0; a < N; a++) begin mem[a] = '0; sa1[a] = '0; end
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_plain(0, "R8", 0, 0);
    t_plain(0, "R8", 0, 0);
    t_plain(1, "R9", 0, 0);
    t_plain(2, "R10", 0, 0);
    t_plain(2, "R10", 0, 0);
    t_plain(3, "R11", 1, 32'hC0FF_EE11);
    t_plain(3, "R11", 0, 0);
    t_plain(1, "R12", 0, 0);
    t_fault();
    t_backpressure();
    t_start_ignored();
    t_plain(3, "R12", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule